// File: doc/BRIEF.md
# Multi-Page-Size Translation Buffer with Access Check

This block is a fully associative translation buffer. It turns a 32-bit effective address into a physical address. Alongside the address it returns the page's cache attributes and a verdict on whether the access may proceed. Each entry maps a page of one of four sizes. Each entry is tagged with a 4-bit address-space number, unless it is marked shared. A 4 KB page may split its protection into four 1 KB subpages. Permission comes either from a 2-bit page code or, in domain mode, from a per-domain override held in a 32-bit access register.

Software fills the buffer through a load port, which places entries in round-robin order. It can drop every entry at once and read any entry back by index. The lookup port takes an address, an access type, a privilege flag and the current address space, and returns a registered result one cycle later. When translation is switched off, the address passes through unchanged and programmable default attributes apply.

Top module: `mpsz_tlb`

## Requirements
- R1: After reset every entry is invalid, the load pointer is 0 and `rs_valid` is low.
- R2: Page size code 0/1/2/3 selects 4 KB/16 KB/512 KB/8 MB. Only address bits above 12/14/19/23 take part in the match. The physical address takes those upper bits from the entry's frame number and the lower bits from the effective address.
- R3: An entry matches only when its address-space number equals `lk_asid`, or when its shared bit is set.
- R4: For a 4 KB page with the subpage bit set, the 2-bit protection code is `ld_prot[2k+1:2k]`, where k = EA[11:10]. For a 4 KB page without the subpage bit, and for every larger page, the code is `ld_prot[1:0]`.
- R5: Access type 00 is a read, 01 a write, and 10 or 11 a fetch (checked as a read). Protection code 00 allows supervisor only. Code 01 allows supervisor read/write and user read. Code 10 allows all accesses. Code 11 allows reads only.
- R6: With `dm_mode` high, the entry's domain d selects `dom_acr[2d+1:2d]`. Field 00 or 10 always faults. Field 01 applies the page code. Field 11 allows any access.
- R7: Fault codes are 00 none, 01 miss, 10 protection and 11 changed. A write to an allowed page whose changed bit is clear reports 11. Reads and fetches never report 11. A miss takes precedence over a protection fault, and a protection fault over a changed fault.
- R8: On a hit, `rs_wt`, `rs_ci` and `rs_grd` carry the entry's bits. On a miss, the address and attributes read 0.
- R9: With `xlat_en` low, the result is a hit with `rs_pa` equal to the effective address, `rs_wt`/`rs_ci` taken from `dflt_wt`/`dflt_ci`, guarded 0 and fault 00.
- R10: A load writes the entry at the pointer and advances the pointer modulo 16. `inv_all` clears every valid bit in one cycle and takes priority over a load in the same cycle, which is then dropped with the pointer unchanged. The `rd_*` outputs show entry `rd_idx` combinationally.
- R11: When several entries match, the lowest-numbered one supplies the result.
- R12: The result registers capture on a cycle with `lk_valid` high. `rs_valid` is `lk_valid` delayed one cycle. The other result outputs hold their value while `lk_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ld_en | input | 1 | Load an entry at the pointer |
| ld_vpn | input | 20 | Effective page number, EA[31:12] |
| ld_ppn | input | 20 | Physical frame number, PA[31:12] |
| ld_size | input | 2 | Page size code |
| ld_asid | input | 4 | Address-space tag |
| ld_shared | input | 1 | Match any address space |
| ld_subpg | input | 1 | Enable 1 KB subpage protection |
| ld_prot | input | 8 | Four 2-bit protection codes |
| ld_dom | input | 4 | Domain number |
| ld_chg | input | 1 | Changed bit |
| ld_wt | input | 1 | Write-through |
| ld_ci | input | 1 | Cache-inhibit |
| ld_grd | input | 1 | Guarded |
| inv_all | input | 1 | Invalidate every entry |
| rd_idx | input | 4 | Readback index |
| rd_valid | output | 1 | Readback valid bit |
| rd_vpn | output | 20 | Readback page number |
| rd_ppn | output | 20 | Readback frame number |
| rd_size | output | 2 | Readback size code |
| rd_asid | output | 4 | Readback address-space tag |
| xlat_en | input | 1 | Translation enable |
| dm_mode | input | 1 | Domain-override protection mode |
| dom_acr | input | 32 | Domain access register |
| dflt_wt | input | 1 | Write-through when translation is off |
| dflt_ci | input | 1 | Cache-inhibit when translation is off |
| lk_valid | input | 1 | Lookup request |
| lk_ea | input | 32 | Effective address |
| lk_acc | input | 2 | Access type |
| lk_user | input | 1 | User privilege |
| lk_asid | input | 4 | Current address space |
| rs_valid | output | 1 | Result valid |
| rs_hit | output | 1 | Translation found |
| rs_pa | output | 32 | Physical address |
| rs_wt | output | 1 | Write-through attribute |
| rs_ci | output | 1 | Cache-inhibit attribute |
| rs_grd | output | 1 | Guarded attribute |
| rs_fault | output | 2 | Fault code |

## Verification
The bench goes after address bits lying just inside and just outside each page size. A design that masks the wrong number of bits would hit where it should miss, or would splice the frame number at the wrong bit. It loads duplicate translations to expose a priority encoder that favours the highest index. It also pairs a load with an invalidate in the same cycle, where a wrong priority leaves a stale valid entry. Subpage fields, every domain code and writes to unchanged pages are covered, so a swapped field, a wrong treatment of the reserved code, or a changed fault raised on reads or fetches each shows up as a wrong fault code.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int ASID_W = 4;
  localparam int DOM_W  = 4;
  localparam int ACR_W  = 2 << DOM_W;

  localparam logic [1:0] F_NONE = 2'b00;
  localparam logic [1:0] F_MISS = 2'b01;
  localparam logic [1:0] F_PROT = 2'b10;
  localparam logic [1:0] F_CHG  = 2'b11;

  typedef struct packed {
    logic [19:0]       vpn;
    logic [19:0]       ppn;
    logic [1:0]        size;
    logic [ASID_W-1:0] asid;
    logic              shared;
    logic              subpg;
    logic [7:0]        prot;
    logic [DOM_W-1:0]  dom;
    logic              chg;
    logic              wt;
    logic              ci;
    logic              grd;
  } entry_t;

  // page-number bits ignored by the tag compare, per size code
  function automatic logic [19:0] size_ign(input logic [1:0] sz);
    case (sz)
      2'd0:    return 20'h00000;
      2'd1:    return 20'h00003;
      2'd2:    return 20'h0007f;
      default: return 20'h007ff;
    endcase
  endfunction

  function automatic logic [31:0] xlate_pa(input entry_t e, input logic [31:0] ea);
    logic [31:0] offm;
    offm = {size_ign(e.size), 12'hfff};
    return ({e.ppn, 12'h000} & ~offm) | (ea & offm);
  endfunction

  function automatic logic pp_allows(input logic [1:0] pp, input logic user,
                                     input logic wr);
    case (pp)
      2'b00:   return !user;
      2'b01:   return !user || !wr;
      2'b10:   return 1'b1;
      default: return !wr;
    endcase
  endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int IDX_W = $clog2(N_ENT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_en,
  input  logic                   inv_all,
  input  entry_t                 ld_ent,
  output entry_t [N_ENT-1:0]     ents,
  output logic   [N_ENT-1:0]     vld,
  output logic   [IDX_W-1:0]     ptr
);
  logic do_load;
  assign do_load = ld_en && !inv_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= '0;
      ptr  <= '0;
      ents <= '0;
    end else if (inv_all) begin
      vld <= '0;
    end else if (do_load) begin
      vld[ptr]  <= 1'b1;
      ents[ptr] <= ld_ent;
      ptr       <= (ptr == IDX_W'(N_ENT - 1)) ? '0 : ptr + 1'b1;
    end
  end

  // R10
  inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (vld == '0));
  // R10
  load_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> (vld[$past(ptr)] && ents[$past(ptr)] == $past(ld_ent)));
  // R10
  inv_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> $stable(ptr));
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int IDX_W = $clog2(N_ENT)
) (
  input  entry_t [N_ENT-1:0]  ents,
  input  logic   [N_ENT-1:0]  vld,
  input  logic   [31:0]       ea,
  input  logic   [ASID_W-1:0] asid,
  output logic   [N_ENT-1:0]  match_vec,
  output logic                any_hit,
  output logic   [IDX_W-1:0]  sel_idx
);
  for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
    logic tag_eq, space_ok;
    assign tag_eq   = ((ea[31:12] ^ ents[i].vpn) & ~size_ign(ents[i].size)) == 20'h0;
    assign space_ok = ents[i].shared || (ents[i].asid == asid);
    assign match_vec[i] = vld[i] && tag_eq && space_ok;
  end

  always_comb begin
    sel_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (match_vec[i]) sel_idx = IDX_W'(i);
  end

  assign any_hit = |match_vec;
endmodule

// File: rtl/tlb_check.sv
module tlb_check
  import tlb_pkg::*;
(
  input  entry_t            e,
  input  logic              hit,
  input  logic [1:0]        ea_sub,
  input  logic [1:0]        acc,
  input  logic              user,
  input  logic              dm_mode,
  input  logic [ACR_W-1:0]  acr,
  output logic [1:0]        fault
);
  logic       is_wr, pp_ok, allowed;
  logic [1:0] pp, dfield;

  assign is_wr  = (acc == 2'b01);
  assign pp     = (e.size == 2'd0 && e.subpg) ? e.prot[{ea_sub, 1'b0} +: 2] : e.prot[1:0];
  assign pp_ok  = pp_allows(pp, user, is_wr);
  assign dfield = acr[{e.dom, 1'b0} +: 2];

  always_comb begin
    if (!dm_mode)             allowed = pp_ok;
    else if (dfield == 2'b11) allowed = 1'b1;
    else if (dfield == 2'b01) allowed = pp_ok;
    else                      allowed = 1'b0;
  end

  always_comb begin
    if (!hit)                fault = F_MISS;
    else if (!allowed)       fault = F_PROT;
    else if (is_wr && !e.chg) fault = F_CHG;
    else                     fault = F_NONE;
  end
endmodule

// File: rtl/mpsz_tlb.sv
module mpsz_tlb
  import tlb_pkg::*;
#(
  parameter int N_ENT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_en,
  input  logic [19:0] ld_vpn,
  input  logic [19:0] ld_ppn,
  input  logic [1:0]  ld_size,
  input  logic [3:0]  ld_asid,
  input  logic        ld_shared,
  input  logic        ld_subpg,
  input  logic [7:0]  ld_prot,
  input  logic [3:0]  ld_dom,
  input  logic        ld_chg,
  input  logic        ld_wt,
  input  logic        ld_ci,
  input  logic        ld_grd,
  input  logic        inv_all,
  input  logic [3:0]  rd_idx,
  output logic        rd_valid,
  output logic [19:0] rd_vpn,
  output logic [19:0] rd_ppn,
  output logic [1:0]  rd_size,
  output logic [3:0]  rd_asid,
  input  logic        xlat_en,
  input  logic        dm_mode,
  input  logic [31:0] dom_acr,
  input  logic        dflt_wt,
  input  logic        dflt_ci,
  input  logic        lk_valid,
  input  logic [31:0] lk_ea,
  input  logic [1:0]  lk_acc,
  input  logic        lk_user,
  input  logic [3:0]  lk_asid,
  output logic        rs_valid,
  output logic        rs_hit,
  output logic [31:0] rs_pa,
  output logic        rs_wt,
  output logic        rs_ci,
  output logic        rs_grd,
  output logic [1:0]  rs_fault
);
  localparam int IDX_W = $clog2(N_ENT);

  entry_t [N_ENT-1:0] ents;
  logic   [N_ENT-1:0] vld;
  logic   [IDX_W-1:0] ptr;
  logic   [N_ENT-1:0] match_vec;
  logic               any_hit;
  logic   [IDX_W-1:0] sel_idx;
  logic   [1:0]       chk_fault;
  entry_t             ld_ent, sel_e, rd_e;

  assign ld_ent = '{vpn: ld_vpn, ppn: ld_ppn, size: ld_size, asid: ld_asid,
                    shared: ld_shared, subpg: ld_subpg, prot: ld_prot, dom: ld_dom,
                    chg: ld_chg, wt: ld_wt, ci: ld_ci, grd: ld_grd};

  tlb_store #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_store (
    .clk, .rst_n, .ld_en, .inv_all, .ld_ent, .ents, .vld, .ptr);

  tlb_match #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_match (
    .ents, .vld, .ea(lk_ea), .asid(lk_asid), .match_vec, .any_hit, .sel_idx);

  assign sel_e = ents[sel_idx];

  tlb_check u_check (
    .e(sel_e), .hit(any_hit), .ea_sub(lk_ea[11:10]), .acc(lk_acc), .user(lk_user),
    .dm_mode, .acr(dom_acr), .fault(chk_fault));

  assign rd_e     = ents[rd_idx[IDX_W-1:0]];
  assign rd_valid = vld[rd_idx[IDX_W-1:0]];
  assign rd_vpn   = rd_e.vpn;
  assign rd_ppn   = rd_e.ppn;
  assign rd_size  = rd_e.size;
  assign rd_asid  = rd_e.asid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_pa    <= '0;
      rs_wt    <= 1'b0;
      rs_ci    <= 1'b0;
      rs_grd   <= 1'b0;
      rs_fault <= F_NONE;
    end else begin
      rs_valid <= lk_valid;
      if (lk_valid) begin
        if (!xlat_en) begin
          rs_hit   <= 1'b1;
          rs_pa    <= lk_ea;
          rs_wt    <= dflt_wt;
          rs_ci    <= dflt_ci;
          rs_grd   <= 1'b0;
          rs_fault <= F_NONE;
        end else begin
          rs_hit   <= any_hit;
          rs_pa    <= any_hit ? xlate_pa(sel_e, lk_ea) : '0;
          rs_wt    <= any_hit && sel_e.wt;
          rs_ci    <= any_hit && sel_e.ci;
          rs_grd   <= any_hit && sel_e.grd;
          rs_fault <= chk_fault;
        end
      end
    end
  end

  // R11
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> (match_vec[sel_idx] &&
                 ((match_vec & ((N_ENT'(1) << sel_idx) - N_ENT'(1))) == '0)));
  // R12
  rs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rs_valid == $past(lk_valid)));
  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> ($stable(rs_pa) && $stable(rs_fault) && $stable(rs_hit)));
  // R9
  xoff_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !xlat_en) |=> (rs_pa == $past(lk_ea) && rs_fault == F_NONE && rs_hit));
  // R7
  miss_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_fault == F_MISS) |-> !rs_hit);
  // R7
  chg_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && xlat_en && lk_acc != 2'b01) |=> (rs_fault != F_CHG));
endmodule

// File: tb/mpsz_tlb_tb.sv
`timescale 1ns/1ps
module mpsz_tlb_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        ld_en = 0, ld_shared = 0, ld_subpg = 0, ld_chg = 0, ld_wt = 0, ld_ci = 0, ld_grd = 0;
  logic [19:0] ld_vpn = 0, ld_ppn = 0;
  logic [1:0]  ld_size = 0;
  logic [3:0]  ld_asid = 0, ld_dom = 0, rd_idx = 0;
  logic [7:0]  ld_prot = 0;
  logic        inv_all = 0, xlat_en = 1, dm_mode = 0, dflt_wt = 0, dflt_ci = 0;
  logic [31:0] dom_acr = 0;
  logic        lk_valid = 0, lk_user = 0;
  logic [31:0] lk_ea = 0;
  logic [1:0]  lk_acc = 0;
  logic [3:0]  lk_asid = 0;
  logic        rd_valid, rs_valid, rs_hit, rs_wt, rs_ci, rs_grd;
  logic [19:0] rd_vpn, rd_ppn;
  logic [1:0]  rd_size, rs_fault;
  logic [3:0]  rd_asid;
  logic [31:0] rs_pa;

  mpsz_tlb u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model of the table
  bit        m_v[16];
  bit [19:0] m_vpn[16], m_ppn[16];
  bit [1:0]  m_sz[16];
  bit [3:0]  m_as[16], m_dom[16];
  bit        m_sh[16], m_sp[16], m_chg[16], m_wt[16], m_ci[16], m_grd[16];
  bit [7:0]  m_pr[16];
  int        m_ptr = 0;

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic int page_bits(bit [1:0] sz);
    if (sz == 0) return 12;
    if (sz == 1) return 14;
    if (sz == 2) return 19;
    return 23;
  endfunction

  function automatic bit rights(bit [1:0] pp, bit user, bit wr);
    if (pp == 2'b10) return 1;
    if (pp == 2'b11) return !wr;
    if (pp == 2'b01) return !user || !wr;
    return !user;
  endfunction

  // returns {hit, pa, wt, ci, grd, fault}
  function automatic bit [37:0] ref_look(bit [31:0] ea, bit [1:0] acc, bit user, bit [3:0] as);
    int k, sh;
    bit wr, ok;
    bit [1:0] pp, df;
    bit [31:0] pa;
    if (!xlat_en) return {1'b1, ea, dflt_wt, dflt_ci, 1'b0, 2'b00};
    k = -1;
    for (int i = 0; i < 16; i++) begin
      sh = page_bits(m_sz[i]);
      if (k < 0 && m_v[i] && (ea >> sh) == ({m_vpn[i], 12'h0} >> sh) && (m_sh[i] || m_as[i] == as))
        k = i;
    end
    if (k < 0) return {1'b0, 32'h0, 3'b000, 2'b01};
    sh = page_bits(m_sz[k]);
    pa = ((({m_ppn[k], 12'h0}) >> sh) << sh) | (ea & ((32'h1 << sh) - 1));
    wr = (acc == 2'b01);
    pp = (m_sz[k] == 0 && m_sp[k]) ? 2'((m_pr[k] >> (2 * int'(ea[11:10]))) & 8'h3) : m_pr[k][1:0];
    ok = rights(pp, user, wr);
    if (dm_mode) begin
      df = 2'((dom_acr >> (2 * int'(m_dom[k]))) & 32'h3);
      if (df == 2'b11) ok = 1;
      else if (df != 2'b01) ok = 0;
    end
    return {1'b1, pa, m_wt[k], m_ci[k], m_grd[k],
            (!ok ? 2'b10 : (wr && !m_chg[k]) ? 2'b11 : 2'b00)};
  endfunction

  task automatic load(bit [19:0] vpn, bit [19:0] ppn, bit [1:0] sz, bit [3:0] as, bit sh,
                      bit sp, bit [7:0] pr, bit [3:0] dm, bit [3:0] attr, bit inv = 0);
    @(negedge clk);
    ld_en = 1; inv_all = inv; ld_vpn = vpn; ld_ppn = ppn; ld_size = sz; ld_asid = as;
    ld_shared = sh; ld_subpg = sp; ld_prot = pr; ld_dom = dm;
    {ld_chg, ld_wt, ld_ci, ld_grd} = attr;
    @(posedge clk); #1;
    ld_en = 0; inv_all = 0;
    if (inv) begin
      for (int i = 0; i < 16; i++) m_v[i] = 0;
    end else begin
      m_v[m_ptr] = 1; m_vpn[m_ptr] = vpn; m_ppn[m_ptr] = ppn; m_sz[m_ptr] = sz;
      m_as[m_ptr] = as; m_sh[m_ptr] = sh; m_sp[m_ptr] = sp; m_pr[m_ptr] = pr;
      m_dom[m_ptr] = dm; {m_chg[m_ptr], m_wt[m_ptr], m_ci[m_ptr], m_grd[m_ptr]} = attr;
      m_ptr = (m_ptr + 1) % 16;
    end
  endtask

  task automatic invalidate();
    @(negedge clk); inv_all = 1;
    @(posedge clk); #1; inv_all = 0;
    for (int i = 0; i < 16; i++) m_v[i] = 0;
  endtask

  task automatic look(string req, bit [31:0] ea, bit [1:0] acc, bit user, bit [3:0] as);
    bit [37:0] e;
    @(negedge clk);
    lk_valid = 1; lk_ea = ea; lk_acc = acc; lk_user = user; lk_asid = as;
    e = ref_look(ea, acc, user, as);
    @(posedge clk); #1;
    lk_valid = 0;
    chk(req, {rs_valid, rs_hit, rs_pa, rs_wt, rs_ci, rs_grd, rs_fault}, {1'b1, e});
  endtask

  task automatic readback(string req, int idx);
    rd_idx = 4'(idx); #1;
    chk(req, rd_valid, m_v[idx]);
    if (m_v[idx]) chk(req, {rd_vpn, rd_ppn, rd_size, rd_asid}, {m_vpn[idx], m_ppn[idx], m_sz[idx], m_as[idx]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed_2024);
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 rs_valid", rs_valid, 0);
    for (int i = 0; i < 16; i++) begin rd_idx = 4'(i); #1; chk("R1 rd_valid", rd_valid, 0); end
    rst_n = 1;
    look("R1 empty miss", 32'h1234_5678, 2'b00, 0, 0);

    // R2 8 MB page
    load(20'h40000, 20'h80000, 2'd3, 4'd3, 0, 0, 8'h02, 0, 4'b1011);
    readback("R10 first slot", 0);
    look("R2 8M inside", 32'h4071_2345, 2'b00, 1, 3);
    look("R2 8M outside", 32'h4081_2345, 2'b00, 1, 3);
    look("R8 attrs on hit", 32'h407F_FFFF, 2'b01, 1, 3);
    // R3 address space
    look("R3 asid mismatch", 32'h4000_0000, 2'b00, 0, 4);
    load(20'h50000, 20'h12345, 2'd2, 4'd9, 1, 0, 8'h02, 0, 4'b1100);
    look("R3 shared hit", 32'h5007_FFFC, 2'b00, 0, 2);
    look("R2 512K outside", 32'h5008_0000, 2'b00, 0, 9);
    // R4 subpage protection and R7 changed fault
    load(20'h10000, 20'h0ABCD, 2'd0, 4'd1, 0, 1, 8'b11_10_01_00, 0, 4'b0001);
    look("R4 sub0 user read", 32'h1000_0100, 2'b00, 1, 1);
    look("R4 sub1 user read", 32'h1000_0500, 2'b10, 1, 1);
    look("R7 sub2 write chg", 32'h1000_0800, 2'b01, 1, 1);
    look("R5 sub3 sup write", 32'h1000_0C00, 2'b01, 0, 1);
    look("R7 read no chg", 32'h1000_0800, 2'b00, 1, 1);
    // R4 subpage bit ignored for 16 KB
    load(20'h20000, 20'h30000, 2'd1, 4'd1, 0, 1, 8'b00_00_00_10, 0, 4'b1000);
    look("R4 16K field0", 32'h2000_3C00, 2'b01, 1, 1);
    look("R2 16K outside", 32'h2000_4000, 2'b00, 1, 1);
    // R6 domain modes on a supervisor-only page, domain 5
    load(20'h60000, 20'h60001, 2'd0, 4'd1, 0, 0, 8'h00, 4'd5, 4'b1000);
    dm_mode = 1;
    for (int f = 0; f < 4; f++) begin
      dom_acr = 32'(f) << 10;
      look("R6 user write", 32'h6000_0010, 2'b01, 1, 1);
      look("R6 sup read", 32'h6000_0010, 2'b00, 0, 1);
    end
    dm_mode = 0;
    // R11 duplicates: lower index wins
    load(20'h70000, 20'h11111, 2'd0, 4'd1, 0, 0, 8'h02, 0, 4'b1000);
    load(20'h70000, 20'h22222, 2'd0, 4'd1, 0, 0, 8'h02, 0, 4'b1111);
    look("R11 lowest index", 32'h7000_0123, 2'b00, 0, 1);
    chk("R11 pa", rs_pa, 32'h1111_1123);
    // R9 translation off
    xlat_en = 0; dflt_wt = 1; dflt_ci = 0;
    look("R9 pass through", 32'hDEAD_BEEF, 2'b01, 1, 7);
    xlat_en = 1;
    // R12 hold while idle
    @(negedge clk); @(posedge clk); #1;
    chk("R12 rs_valid low", rs_valid, 0);
    chk("R12 hold pa", rs_pa, 32'hDEAD_BEEF);
    // R10 wrap and load+invalidate
    for (int i = 0; i < 12; i++) load(20'h90000 + 20'(i), 20'(i), 2'd0, 0, 0, 0, 8'h02, 0, 4'b1000);
    readback("R10 wrap slot0", 0);
    readback("R10 slot1", 1);
    load(20'hA0000, 20'h1, 2'd0, 0, 0, 0, 8'h02, 0, 4'b1000, 1);
    for (int i = 0; i < 16; i++) readback("R10 inv wins", i);
    load(20'hB0000, 20'h2, 2'd0, 0, 0, 0, 8'h02, 0, 4'b1000);
    readback("R10 ptr kept", m_ptr == 0 ? 15 : m_ptr - 1);

    // random phase
    for (int n = 0; n < 1500; n++) begin
      int r, k;
      bit [31:0] ea;
      r = $urandom_range(0, 99);
      if (r < 15) begin
        load(20'($urandom), 20'($urandom), 2'($urandom), 4'($urandom_range(0, 3)), ($urandom_range(0, 3) == 0),
             1'($urandom), 8'($urandom), 4'($urandom), 4'($urandom));
      end else if (r < 16) begin
        invalidate();
      end else begin
        k = $urandom_range(0, 15);
        ea = $urandom;
        if (m_v[k]) ea = {m_vpn[k], 12'h0} ^ (ea & ((32'h1 << page_bits(m_sz[k])) - 1));
        xlat_en = ($urandom_range(0, 9) != 0);
        dm_mode = 1'($urandom);
        dom_acr = $urandom;
        dflt_wt = 1'($urandom); dflt_ci = 1'($urandom);
        look("R2-random", ea, 2'($urandom), 1'($urandom), 4'($urandom_range(0, 3)));
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule